// File: doc/BRIEF.md
# Cascadable Synchronous Preset Binary Counter

This block is a wide binary up-counter assembled from a chain of identical 4-bit stages. Every state change, including the clear, takes effect on the rising clock edge. An active-low clear has the highest priority. An active-low load comes next and copies the preset bus into the count. Two active-high count enables must both be high for the counter to advance. When none of these applies, the count holds.

Each stage produces a look-ahead terminal-count signal. It is the AND of that stage's "trickle" enable and its four count bits all being 1. The signal feeds the trickle enable of the stage above. The "parallel" enable goes to every stage at once. As a result, the chain advances as one synchronous counter of 4·STAGES bits. The terminal count of the top stage is brought out, so several such blocks can be chained further.

Top module: `cnt_chain`

## Requirements
- R1: When `clr_n` is low at a rising edge, `count` becomes 0 after that edge, whatever the levels of `load_n`, `en_p` and `en_t`.
- R2: When `clr_n` is high and `load_n` is low at a rising edge, `count` becomes `preset` after that edge, whatever the levels of `en_p` and `en_t`.
- R3: When `clr_n` and `load_n` are high and both `en_p` and `en_t` are high at a rising edge, `count` increases by exactly one, as a single 4·STAGES-bit binary counter would.
- R4: When `clr_n` and `load_n` are high and either `en_p` or `en_t` is low at a rising edge, `count` keeps its value.
- R5: `tc_out` is high exactly when `en_t` is high and every bit of `count` is 1. It is combinational and does not depend on `en_p`.
- R6: An increment from the all-ones count gives the all-zeros count.
- R7: During free counting, `tc_out` is high for exactly one clock period: after an increment from all ones, `tc_out` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| clr_n | input | 1 | Synchronous clear, active low, top priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_p | input | 1 | Count enable routed to every stage |
| en_t | input | 1 | Count enable that also gates the terminal count |
| preset | input | 4·STAGES | Value loaded when `load_n` is low |
| count | output | 4·STAGES | Current count |
| tc_out | output | 1 | Terminal count of the top stage, for further chaining |

## Verification
The bench builds the block with STAGES=2, which gives an 8-bit chain. With this size, the full wrap through 255 and every carry from the lower stage into the upper one are reached many times within a few thousand cycles. Random clears, loads and enable patterns are checked against a bench model of a plain 8-bit counter. Directed loads near all ones add specific checks: the wrap, the gating of `tc_out` by `en_t` alone, and its single-cycle pulse.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int unsigned STAGE_W = 4;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2,
    OP_HOLD  = 2'd3
  } cnt_op_e;

  // Priority: clear, then load, then count, then hold.
  function automatic cnt_op_e pick_op(input logic clr_n, input logic load_n,
                                      input logic en_p, input logic en_t);
    if (!clr_n)            return OP_CLEAR;
    else if (!load_n)      return OP_LOAD;
    else if (en_p && en_t) return OP_COUNT;
    else                   return OP_HOLD;
  endfunction
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    en_p,
  input  logic    en_t,
  output cnt_op_e op
);
  always_comb op = pick_op(clr_n, load_n, en_p, en_t);
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int unsigned W = STAGE_W
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         tc
);
  localparam logic [W-1:0] ONE = W'(1);

  cnt_op_e op;

  cnt_ctrl u_ctrl (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .op     (op)
  );

  always_ff @(posedge clk) begin
    unique case (op)
      OP_CLEAR: q <= '0;
      OP_LOAD:  q <= din;
      OP_COUNT: q <= q + ONE;
      default:  q <= q;
    endcase
  end

  // Look-ahead carry: gated by the trickle enable only.
  assign tc = en_t & (&q);
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
  import cnt_pkg::*;
#(
  parameter int unsigned STAGES = 4
) (
  input  logic                        clk,
  input  logic                        clr_n,
  input  logic                        load_n,
  input  logic                        en_p,
  input  logic                        en_t,
  input  logic [STAGES*STAGE_W-1:0]   preset,
  output logic [STAGES*STAGE_W-1:0]   count,
  output logic                        tc_out
);
  localparam int unsigned TOTAL_W = STAGES * STAGE_W;

  logic [STAGES:0]   carry;
  logic [STAGES-1:0] stage_tc;

  assign carry[0] = en_t;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    cnt_stage #(.W(STAGE_W)) u_stage (
      .clk    (clk),
      .clr_n  (clr_n),
      .load_n (load_n),
      .en_p   (en_p),
      .en_t   (carry[g]),
      .din    (preset[g*STAGE_W +: STAGE_W]),
      .q      (count[g*STAGE_W +: STAGE_W]),
      .tc     (stage_tc[g])
    );
    assign carry[g+1] = stage_tc[g];
  end

  assign tc_out = carry[STAGES];
endmodule

// File: rtl/cnt_chain_chk.sv
module cnt_chain_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         clr_n,
  input logic         load_n,
  input logic         en_p,
  input logic         en_t,
  input logic [W-1:0] preset,
  input logic [W-1:0] count,
  input logic         tc_out
);
  localparam logic [W-1:0] ALL1 = '1;
  localparam logic [W-1:0] INC  = W'(1);

  // Becomes 1 once a clear has been applied; before that the count is unknown.
  logic primed = 1'b0;
  always_ff @(posedge clk) if (!clr_n) primed <= 1'b1;

  assert_clear_R1: assert property (@(posedge clk)
    !clr_n |=> count == '0);

  assert_load_R2: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && !load_n) |=> count == $past(preset));

  assert_step_R3: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && load_n && en_p && en_t) |=> count == $past(count) + INC);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && load_n && !(en_p && en_t)) |=> $stable(count));

  assert_tc_R5: assert property (@(posedge clk) disable iff (!primed)
    tc_out == (en_t && count == ALL1));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && load_n && en_p && en_t && count == ALL1) |=> count == '0);

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && load_n && en_p && tc_out) |=> !tc_out);
endmodule

bind cnt_chain cnt_chain_chk #(.W(TOTAL_W)) u_chk (
  .clk    (clk),
  .clr_n  (clr_n),
  .load_n (load_n),
  .en_p   (en_p),
  .en_t   (en_t),
  .preset (preset),
  .count  (count),
  .tc_out (tc_out)
);

// File: tb/test_cnt_chain.sv
`timescale 1ns/1ps
module test_cnt_chain;
  localparam int unsigned STAGES = 2;
  localparam int unsigned W = STAGES * 4;
  localparam logic [W-1:0] ALL1 = '1;
  localparam real HALF = 10.0;

  logic clk = 1'b0;
  logic clr_n = 1'b0, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [W-1:0] preset = '0;
  logic [W-1:0] count;
  logic tc_out;

  int total = 0;
  int bad = 0;
  logic [W-1:0] exp_cnt = '0;
  logic prev_wrap = 1'b0;

  always #(HALF) clk = ~clk;

  cnt_chain #(.STAGES(STAGES)) i_cnt_chain (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .preset(preset), .count(count), .tc_out(tc_out)
  );

  function automatic logic [W-1:0] model_next(logic [W-1:0] cur, logic c, logic l,
                                               logic p, logic t, logic [W-1:0] d);
    if (!c) return '0;
    if (!l) return d;
    if (p && t) return cur + W'(1);
    return cur;
  endfunction

  function automatic string which_req(logic [W-1:0] cur, logic c, logic l,
                                      logic p, logic t);
    if (!c) return "R1";
    if (!l) return "R2";
    if (p && t) return (cur == ALL1) ? "R6" : "R3";
    return "R4";
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  // Called just after a falling edge: drive, let one rising edge pass, check.
  task automatic step(logic c, logic l, logic p, logic t, logic [W-1:0] d);
    logic [W-1:0] nxt;
    string req;
    logic wrap;
    clr_n = c; load_n = l; en_p = p; en_t = t; preset = d;
    nxt  = model_next(exp_cnt, c, l, p, t, d);
    req  = which_req(exp_cnt, c, l, p, t);
    wrap = c && l && p && t && (exp_cnt == ALL1);
    @(posedge clk);
    #5;
    check(req, count, nxt);
    check(wrap ? "R7" : "R5", W'(tc_out), W'(t && nxt == ALL1));
    exp_cnt = nxt;
    prev_wrap = wrap;
    @(negedge clk);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // Reset state (R1) with every other control active.
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'hA5);
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h3C);
    // Load ignores enables (R2).
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h0E);
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h0E);
    // Carry from low stage into high stage (R3).
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    // Hold with each enable low (R4).
    step(1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
    step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
    // All ones: tc follows en_t only (R5), then wrap (R6) and pulse end (R7).
    step(1'b1, 1'b0, 1'b0, 1'b1, ALL1);
    step(1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
    step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    // Clear beats load (R1).
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h77);
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h55);
    // Free run across a full cycle of the chain.
    for (int i = 0; i < 300; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    // Constrained random mix.
    for (int i = 0; i < 4000; i++) begin
      logic c, l, p, t;
      logic [W-1:0] d;
      c = ($urandom % 40) != 0;
      l = ($urandom % 20) != 0;
      p = ($urandom % 8) != 0;
      t = ($urandom % 8) != 0;
      d = ($urandom % 4 == 0) ? (ALL1 - W'($urandom % 3)) : W'($urandom);
      step(c, l, p, t, d);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule